// File: doc/BRIEF.md
# Protection Region Address Decoder

This block converts the settings of one memory protection entry into an inclusive byte-address window. The inputs are the entry's two-bit match mode, its own address register, and the address register of the entry just below it. The result is a start address and an end address that range comparators downstream can use directly. An address register stores a byte address with its two lowest bits dropped, so the decoded byte addresses are two bits wider than the register.

The decode runs only when software has changed the entry. The caller pulses an update strobe at that point. The window is captured on that clock edge and held until the next strobe, so the comparators always see a stable pair of bounds. A separate input tells the block that it is serving the lowest entry, which has no lower neighbour.

Top module: `region_dec`

## Requirements
- R1: While reset is asserted and after reset is released, both `rangeStart` and `rangeEnd` read zero until the first update strobe.
- R2: Values present with `updStb` high are decoded and appear on the outputs after that rising edge. Changes to the inputs while `updStb` is low leave both outputs unchanged.
- R3: The mode field uses 0 = off, 1 = top-of-range, 2 = four-byte, 3 = power-of-two. Off decodes to start 0 and end all ones.
- R4: Top-of-range decodes to start = `prevAddr`·4 and end = `curAddr`·4 − 1, modulo 2^(REG_W+2). A `curAddr` of zero therefore wraps the end to all ones.
- R5: In top-of-range mode with `firstEntry` high, `prevAddr` is treated as zero and start is 0, whatever value `prevAddr` holds.
- R6: Four-byte mode decodes to start = `curAddr`·4 and end = start + 3.
- R7: In power-of-two mode with t trailing ones in `curAddr` (t < REG_W), the region spans 2^(t+3) bytes. Start is `curAddr` with its low t+1 bits cleared, times 4, and end is start + 2^(t+3) − 1.
- R8: In power-of-two mode an all-ones `curAddr` decodes to the whole space: start 0, end all ones.
- R9: The outputs are REG_W+2 bits wide, and the top register bits reach the top output bits without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| updStb | input | 1 | Decode and capture the inputs on this edge |
| mode | input | 2 | Match mode of this entry |
| firstEntry | input | 1 | High when this is the lowest entry, so no lower neighbour exists |
| curAddr | input | REG_W | This entry's address register (byte address bits REG_W+1:2) |
| prevAddr | input | REG_W | Address register of the entry below |
| rangeStart | output | REG_W+2 | Inclusive start byte address |
| rangeEnd | output | REG_W+2 | Inclusive end byte address |

## Verification
Some properties are checked on every cycle. Outputs hold when no strobe is present. A four-byte window is always exactly four bytes. A power-of-two window is always a naturally aligned power-of-two block. Off mode gives the full span, and the lowest entry's top-of-range start is zero. Exact bound values need the bench's scenarios. These include trailing-one counts of zero, small, REG_W−1 and all ones, the end wrap in top-of-range with a zero register, and four-byte windows at the top of the space.

// File: rtl/region_dec_pkg.sv
package region_dec_pkg;

  // Mode field encoding, decoded by the configuration logic of neighbours
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic load;
    logic useTor;
    logic useNa4;
    logic useNapot;
    logic zeroPrev;
  } dec_ctrl_t;

endpackage

// File: rtl/region_dec_ctrl.sv
module region_dec_ctrl
  import region_dec_pkg::*;
(
  input  logic        updStb,
  input  logic [1:0]  mode,
  input  logic        firstEntry,
  output dec_ctrl_t   ctrlOut
);

  match_mode_e modeE;

  always_comb begin
    modeE            = match_mode_e'(mode);
    ctrlOut          = '0;
    ctrlOut.load     = updStb;
    ctrlOut.zeroPrev = firstEntry;
    unique case (modeE)
      MODE_TOR:   ctrlOut.useTor   = 1'b1;
      MODE_NA4:   ctrlOut.useNa4   = 1'b1;
      MODE_NAPOT: ctrlOut.useNapot = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/region_dec_path.sv
module region_dec_path
  import region_dec_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dec_ctrl_t           ctrlIn,
  input  logic [REG_W-1:0]    curAddr,
  input  logic [REG_W-1:0]    prevAddr,
  output logic [REG_W+1:0]    rangeStart,
  output logic [REG_W+1:0]    rangeEnd
);

  localparam int BYTE_W = REG_W + 2;
  localparam int CNT_W  = $clog2(REG_W + 1);

  logic [BYTE_W-1:0] curByte, prevByte;
  logic [BYTE_W-1:0] napMask, napStart, napEnd;
  logic [BYTE_W-1:0] nextStart, nextEnd;
  logic [CNT_W-1:0]  onesCnt;
  logic              allOnes;

  assign curByte  = {curAddr, 2'b00};
  assign prevByte = ctrlIn.zeroPrev ? '0 : {prevAddr, 2'b00};
  assign allOnes  = &curAddr;

  // Priority encoder: count of trailing ones in the address register
  always_comb begin
    logic seenZero;
    seenZero = 1'b0;
    onesCnt  = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (!seenZero && curAddr[i]) onesCnt = onesCnt + 1'b1;
      else seenZero = 1'b1;
    end
  end

  // Byte-level mask of the region size: bits below onesCnt+3
  for (genvar b = 0; b < BYTE_W; b++) begin : g_mask
    assign napMask[b] = (b < (int'(onesCnt) + 3));
  end

  assign napStart = allOnes ? '0 : (curByte & ~napMask);
  assign napEnd   = allOnes ? '1 : (napStart | napMask);

  always_comb begin
    nextStart = '0;
    nextEnd   = '1;
    if (ctrlIn.useTor) begin
      nextStart = prevByte;
      nextEnd   = curByte - 1'b1;
    end else if (ctrlIn.useNa4) begin
      nextStart = curByte;
      nextEnd   = curByte + BYTE_W'(3);
    end else if (ctrlIn.useNapot) begin
      nextStart = napStart;
      nextEnd   = napEnd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rangeStart <= '0;
      rangeEnd   <= '0;
    end else if (ctrlIn.load) begin
      rangeStart <= nextStart;
      rangeEnd   <= nextEnd;
    end
  end

  logic [BYTE_W-1:0] spanM1;
  assign spanM1 = rangeEnd - rangeStart;

  // R2
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.load |=> ($stable(rangeStart) && $stable(rangeEnd)));

  // R3
  off_full_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.load && !ctrlIn.useTor && !ctrlIn.useNa4 && !ctrlIn.useNapot)
      |=> (rangeStart == '0 && rangeEnd == '1));

  // R5
  first_tor_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.load && ctrlIn.useTor && ctrlIn.zeroPrev) |=> (rangeStart == '0));

  // R6
  na4_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.load && ctrlIn.useNa4) |=> (spanM1 == BYTE_W'(3)));

  // R7
  napot_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlIn.load && ctrlIn.useNapot)
      |=> (((spanM1 + 1'b1) & spanM1) == '0 && (rangeStart & spanM1) == '0
           && spanM1 >= BYTE_W'(7)));

endmodule

// File: rtl/region_dec.sv
module region_dec
  import region_dec_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               updStb,
  input  logic [1:0]         mode,
  input  logic               firstEntry,
  input  logic [REG_W-1:0]   curAddr,
  input  logic [REG_W-1:0]   prevAddr,
  output logic [REG_W+1:0]   rangeStart,
  output logic [REG_W+1:0]   rangeEnd
);

  dec_ctrl_t ctrlBus;

  region_dec_ctrl u_ctrl (
    .updStb     (updStb),
    .mode       (mode),
    .firstEntry (firstEntry),
    .ctrlOut    (ctrlBus)
  );

  region_dec_path #(.REG_W(REG_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlIn     (ctrlBus),
    .curAddr    (curAddr),
    .prevAddr   (prevAddr),
    .rangeStart (rangeStart),
    .rangeEnd   (rangeEnd)
  );

endmodule

// File: tb/sim_region_dec.sv
`timescale 1ns/100ps
module sim_region_dec;

  localparam int REG_W  = 32;
  localparam int BYTE_W = REG_W + 2;

  typedef struct {
    logic [BYTE_W-1:0] expStart;
    logic [BYTE_W-1:0] expEnd;
    string             tag;
  } exp_item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              updStb = 1'b0;
  logic [1:0]        mode = '0;
  logic              firstEntry = 1'b0;
  logic [REG_W-1:0]  curAddr = '0;
  logic [REG_W-1:0]  prevAddr = '0;
  logic [BYTE_W-1:0] rangeStart, rangeEnd;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;
  exp_item_t expQ[$];
  exp_item_t lastExp;

  always #2.5 clk = ~clk;

  region_dec #(.REG_W(REG_W)) u0 (
    .clk(clk), .rstN(rstN), .updStb(updStb), .mode(mode),
    .firstEntry(firstEntry), .curAddr(curAddr), .prevAddr(prevAddr),
    .rangeStart(rangeStart), .rangeEnd(rangeEnd)
  );

  // Reference model written from the requirements
  function automatic exp_item_t model(input logic [1:0] m, input logic [REG_W-1:0] c,
                                      input logic [REG_W-1:0] p, input logic f,
                                      input string tag);
    exp_item_t e;
    logic [BYTE_W:0] sz;
    int t;
    e.tag = tag;
    case (m)
      2'd1: begin
        e.expStart = f ? '0 : BYTE_W'(p) << 2;
        e.expEnd   = (BYTE_W'(c) << 2) - 1;
      end
      2'd2: begin
        e.expStart = BYTE_W'(c) << 2;
        e.expEnd   = e.expStart + 3;
      end
      2'd3: begin
        t = 0;
        while (t < REG_W && c[t]) t++;
        if (t == REG_W) begin
          e.expStart = '0;
          e.expEnd   = '1;
        end else begin
          e.expStart = (BYTE_W'(c) >> (t + 1)) << (t + 3);
          sz         = (BYTE_W+1)'(1) << (t + 3);
          e.expEnd   = e.expStart + BYTE_W'(sz - 1);
        end
      end
      default: begin
        e.expStart = '0;
        e.expEnd   = '1;
      end
    endcase
    return e;
  endfunction

  // Driver: apply with strobe and push expected
  task automatic applyVec(input logic [1:0] m, input logic [REG_W-1:0] c,
                          input logic [REG_W-1:0] p, input logic f, input string tag);
    @(negedge clk);
    mode = m; curAddr = c; prevAddr = p; firstEntry = f; updStb = 1'b1;
    lastExp = model(m, c, p, f, tag);
    @(negedge clk);
    updStb = 1'b0;
    expQ.push_back(lastExp);
  endtask

  // Driver: change inputs without strobe, outputs must hold
  task automatic holdVec(input logic [1:0] m, input logic [REG_W-1:0] c,
                         input logic [REG_W-1:0] p, input string tag);
    exp_item_t e;
    @(negedge clk);
    mode = m; curAddr = c; prevAddr = p; updStb = 1'b0;
    @(negedge clk);
    e = lastExp;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_item_t e;
        e = expQ.pop_front();
        vecCnt++;
        if (rangeStart !== e.expStart || rangeEnd !== e.expEnd) begin
          errCnt++;
          $display("FAIL %s: got start=%h end=%h, expected start=%h end=%h",
                   e.tag, rangeStart, rangeEnd, e.expStart, e.expEnd);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    exp_item_t r;
    repeat (3) @(negedge clk);
    r.expStart = '0; r.expEnd = '0; r.tag = "R1 in reset";
    expQ.push_back(r);
    @(negedge clk);
    rstN = 1'b1;
    r.tag = "R1 after release";
    lastExp = r;
    expQ.push_back(r);
    repeat (2) @(negedge clk);

    applyVec(2'd0, 32'h1234_5678, 32'h0, 1'b0, "R3 off full span");
    applyVec(2'd1, 32'h0000_2000, 32'h0000_1000, 1'b0, "R4 tor basic");
    holdVec (2'd2, 32'hDEAD_BEEF, 32'h1, "R2 hold no strobe");
    holdVec (2'd3, 32'h0, 32'hFFFF_FFFF, "R2 hold second");
    applyVec(2'd1, 32'h0000_0000, 32'h0000_0040, 1'b0, "R4 tor end wraps");
    applyVec(2'd1, 32'h0000_0800, 32'hABCD_0000, 1'b1, "R5 first entry prev ignored");
    applyVec(2'd2, 32'h0000_0101, 32'h0, 1'b0, "R6 na4 basic");
    applyVec(2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, "R6 R9 na4 top of space");
    applyVec(2'd3, 32'h0000_1000, 32'h0, 1'b0, "R7 napot t=0");
    applyVec(2'd3, 32'h0000_1001, 32'h0, 1'b0, "R7 napot t=1");
    applyVec(2'd3, 32'h8765_403F, 32'h0, 1'b0, "R7 napot t=6");
    applyVec(2'd3, 32'h7FFF_FFFF, 32'h0, 1'b0, "R7 napot t=31");
    applyVec(2'd3, 32'hFFFF_FFFF, 32'h0, 1'b0, "R8 napot all ones");
    applyVec(2'd3, 32'hC000_0000, 32'h0, 1'b0, "R9 napot high bits");
    applyVec(2'd1, 32'hF000_0000, 32'hC000_0000, 1'b0, "R9 tor high bits");
    holdVec (2'd0, 32'h5, 32'h6, "R2 hold after high bits");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule